// File: doc/BRIEF.md
# Device Power State Controller

This block keeps the power state of one peripheral function on a shared bus and acts on software requests to change it. Software writes a requested state through a configuration write. The block checks the request against the states this instance supports and against a fixed set of legal moves. It then updates the current state one clock edge after the write. Memory and I/O decoding are allowed only in the full-power state. Configuration writes are taken in every state, so software can always bring the function back.

A 5-bit capability mask, fixed per instance, says in which states the function may raise a wake event. An enable bit and a sticky status bit (cleared by writing 1) form the wake-signalling pair. The wake output is the status qualified by the enable. When the function leaves the deepest software-reachable low-power state, a recovery window counted in clock cycles keeps decoding off and raises a busy flag. Removing the supply is modelled by the asynchronous reset, which restores every register to its default.

Top module: `pm_state_ctrl`

## Requirements
- R1: After reset the state field reads 0 (full power), wake enable and wake status read 0, decode_en_o is 1, busy_o is 0 and wake_o is 0.
- R2: The control word places the state in bits 1:0 (0 full power, 1 light sleep, 2 deep sleep, 3 soft-off), the wake enable in bit 4 and the wake status in bit 7, for both write and read. An accepted state request shows in ctrl_o bits 1:0 on the clock edge that samples the write.
- R3: The accepted moves are from 0 to 1, 2 or 3; from 1 to 2 or 3; from 2 to 3; and from 1, 2 or 3 to 0. Any other request, including a request for the current state, leaves the state unchanged.
- R4: States 0 and 3 are always supported. State 1 is supported only when D1_EN is 1 and NO_MID is 0, and state 2 only when D2_EN is 1 and NO_MID is 0. A request for an unsupported state is ignored.
- R5: decode_en_o is 1 only in state 0 outside a recovery window. Configuration writes change the wake bits and the state in every state.
- R6: An accepted move from state 3 to state 0 raises busy_o for exactly RECOVERY_MS*CLK_KHZ cycles, starting at the same edge. decode_en_o stays 0 during that window.
- R7: While busy_o is 1, state requests are ignored.
- R8: The wake status sets on a cycle where wake_evt_i is 1 and the capability bit of the current state is 1. The capability bits are 0 for state 0 up to 3 for state 3 and bit 4 for the unpowered state. The status does not set when that capability bit is 0.
- R9: wake_o is 1 exactly when both the wake status and the wake enable are 1.
- R10: Writing 1 to bit 7 clears the wake status. If an event sets the status in the same cycle as the clear, the status stays set.
- R11: wake_cap_o always presents the WAKE_CAP parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; also models supply removal |
| cfg_wr_i | input | 1 | Configuration write strobe for the control word |
| cfg_wdata_i | input | 8 | Control word write data |
| wake_evt_i | input | 1 | External wake event pulse |
| ctrl_o | output | 8 | Control word read-back |
| wake_cap_o | output | 5 | Wake capability mask per state |
| decode_en_o | output | 1 | Memory and I/O decode enable |
| busy_o | output | 1 | Recovery window in progress |
| wake_o | output | 1 | Wake event request |

## Verification
A bad state register shows up in ctrl_o bits 1:0 and in decode_en_o one edge after the write that caused it. The sweep checks every start state a configuration can reach against every request. Two instances with different optional-state support are driven from the same stimulus, so a support check that is wrong makes the two read-backs differ. A timer that counts wrong shows as a busy window that is too short or too long. Wake status errors appear at the next edge after an event, in both the status bit and wake_o.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PS_FULL = 2'd0,
    PS_LITE = 2'd1,
    PS_DEEP = 2'd2,
    PS_OFF  = 2'd3
  } pstate_e;

  localparam int CW_W      = 8;
  localparam int F_STATE_L = 0;
  localparam int F_WEN     = 4;
  localparam int F_WSTS    = 7;
  localparam int CAP_W     = 5;
endpackage

// File: rtl/pm_trans_check.sv
module pm_trans_check
  import pm_pkg::*;
#(
  parameter bit D1_EN  = 1'b1,
  parameter bit D2_EN  = 1'b1,
  parameter bit NO_MID = 1'b0
) (
  input  pstate_e cur_i,
  input  pstate_e req_i,
  output logic    ok_o
);
  localparam bit LITE_OK = D1_EN && !NO_MID;
  localparam bit DEEP_OK = D2_EN && !NO_MID;

  logic supported, legal;

  always_comb begin
    unique case (req_i)
      PS_LITE: supported = LITE_OK;
      PS_DEEP: supported = DEEP_OK;
      default: supported = 1'b1;
    endcase
    // deeper moves only, or a return to full power
    legal = (req_i != cur_i) && ((req_i == PS_FULL) || (req_i > cur_i));
    ok_o  = supported && legal;
  end
endmodule

// File: rtl/pm_recovery_timer.sv
module pm_recovery_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD); // R6
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o); // R6
endmodule

// File: rtl/pm_wake_logic.sv
module pm_wake_logic
  import pm_pkg::*;
#(
  parameter logic [CAP_W-1:0] CAP = 5'b01001
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  pstate_e state_i,
  input  logic    evt_i,
  input  logic    wr_i,
  input  logic    wen_wdata_i,
  input  logic    clr_wdata_i,
  output logic    wen_o,
  output logic    sts_o,
  output logic    wake_o
);
  logic set_ev;

  assign set_ev = evt_i && CAP[state_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_o <= 1'b0;
      sts_o <= 1'b0;
    end else begin
      if (wr_i) wen_o <= wen_wdata_i;
      // set wins over a same-cycle clear
      if (set_ev)                   sts_o <= 1'b1;
      else if (wr_i && clr_wdata_i) sts_o <= 1'b0;
    end
  end

  assign wake_o = sts_o && wen_o;

  AST_WAKE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> wen_o); // R9
  AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_o && !(wr_i && clr_wdata_i) |=> sts_o); // R10
  AST_NO_CAP_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_o && !(evt_i && CAP[state_i]) |=> !sts_o); // R8
endmodule

// File: rtl/pm_state_ctrl.sv
module pm_state_ctrl
  import pm_pkg::*;
#(
  parameter bit               D1_EN       = 1'b1,
  parameter bit               D2_EN       = 1'b1,
  parameter bit               NO_MID      = 1'b0,
  parameter logic [CAP_W-1:0] WAKE_CAP    = 5'b01001,
  parameter int               RECOVERY_MS = 10,
  parameter int               CLK_KHZ     = 100000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic [CW_W-1:0]  cfg_wdata_i,
  input  logic             wake_evt_i,
  output logic [CW_W-1:0]  ctrl_o,
  output logic [CAP_W-1:0] wake_cap_o,
  output logic             decode_en_o,
  output logic             busy_o,
  output logic             wake_o
);
  localparam int RECOV_CYC = RECOVERY_MS * CLK_KHZ;

  pstate_e state_q, req;
  logic    ok, take, rec_start, wen, sts;

  assign req = pstate_e'(cfg_wdata_i[F_STATE_L +: 2]);

  pm_trans_check #(.D1_EN(D1_EN), .D2_EN(D2_EN), .NO_MID(NO_MID)) u_chk (
    .cur_i(state_q), .req_i(req), .ok_o(ok)
  );

  assign take      = cfg_wr_i && ok && !busy_o;
  assign rec_start = take && (state_q == PS_OFF) && (req == PS_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   state_q <= PS_FULL;
    else if (take) state_q <= req;
  end

  pm_recovery_timer #(.CYCLES(RECOV_CYC)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(rec_start), .busy_o(busy_o)
  );

  pm_wake_logic #(.CAP(WAKE_CAP)) u_wake (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state_q), .evt_i(wake_evt_i),
    .wr_i(cfg_wr_i), .wen_wdata_i(cfg_wdata_i[F_WEN]),
    .clr_wdata_i(cfg_wdata_i[F_WSTS]),
    .wen_o(wen), .sts_o(sts), .wake_o(wake_o)
  );

  always_comb begin
    ctrl_o                  = '0;
    ctrl_o[F_STATE_L +: 2]  = state_q;
    ctrl_o[F_WEN]           = wen;
    ctrl_o[F_WSTS]          = sts;
  end

  assign wake_cap_o  = WAKE_CAP;
  assign decode_en_o = (state_q == PS_FULL) && !busy_o;

  AST_HOLD_ON_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i && !(ok && !busy_o) |=> state_q == $past(state_q)); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !$rose(busy_o) |-> $stable(state_q)); // R7
  AST_DEC_OFF_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !decode_en_o); // R6
  AST_RECOV_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> state_q == PS_FULL && $past(state_q) == PS_OFF); // R6
  AST_NO_LITE_UNSUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(D1_EN && !NO_MID) |-> state_q != PS_LITE); // R4
  AST_NO_DEEP_UNSUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(D2_EN && !NO_MID) |-> state_q != PS_DEEP); // R4
endmodule

// File: tb/pm_state_ctrl_test.sv
module pm_state_ctrl_test;
  localparam int PERIOD = 10;
  localparam int RMS = 2;
  localparam int KHZ = 5;
  localparam int RC  = RMS * KHZ;
  localparam logic [4:0] CAP = 5'b10011;

  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, evt = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] ctrl_a, ctrl_b;
  logic [4:0] cap_a, cap_b;
  logic dec_a, dec_b, busy_a, busy_b, wake_a, wake_b;
  int checks = 0, errors = 0;
  int ma, mb;
  bit ba, bb;

  always #(PERIOD/2) clk = ~clk;

  // uut: light sleep only; uut_b: middle states forbidden
  pm_state_ctrl #(.D1_EN(1'b1), .D2_EN(1'b0), .NO_MID(1'b0), .WAKE_CAP(CAP),
    .RECOVERY_MS(RMS), .CLK_KHZ(KHZ)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(wr), .cfg_wdata_i(wdata),
    .wake_evt_i(evt), .ctrl_o(ctrl_a), .wake_cap_o(cap_a),
    .decode_en_o(dec_a), .busy_o(busy_a), .wake_o(wake_a));

  pm_state_ctrl #(.D1_EN(1'b1), .D2_EN(1'b1), .NO_MID(1'b1), .WAKE_CAP(CAP),
    .RECOVERY_MS(RMS), .CLK_KHZ(KHZ)) uut_b (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(wr), .cfg_wdata_i(wdata),
    .wake_evt_i(evt), .ctrl_o(ctrl_b), .wake_cap_o(cap_b),
    .decode_en_o(dec_b), .busy_o(busy_b), .wake_o(wake_b));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nxt(int cur, int rq, bit lite, bit deep, bit bsy);
    bit sup = (rq == 0) || (rq == 3) || (rq == 1 && lite) || (rq == 2 && deep);
    bit leg = (rq != cur) && (rq == 0 || rq > cur);
    return (sup && leg && !bsy) ? rq : cur;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    ma = 0; mb = 0; ba = 0; bb = 0;
  endtask

  task automatic do_wr(input int s, input bit en, input bit clr, input bit ev);
    int na, nb;
    @(negedge clk);
    wr = 1'b1; evt = ev;
    wdata = {clr, 2'b00, en, 2'b00, 2'(s)};
    na = nxt(ma, s, 1'b1, 1'b0, ba);
    nb = nxt(mb, s, 1'b0, 1'b0, bb);
    if (ma == 3 && na == 0) ba = 1;
    if (mb == 3 && nb == 0) bb = 1;
    ma = na; mb = nb;
    @(negedge clk);
    wr = 1'b0; evt = 1'b0; wdata = '0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_a && n < 1000) begin n++; @(negedge clk); end
    repeat (2) @(negedge clk);
    ba = 0; bb = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1 state", int'(ctrl_a[1:0]), 0);
    chk("R1 wen", int'(ctrl_a[4]), 0);
    chk("R1 sts", int'(ctrl_a[7]), 0);
    chk("R1 dec", int'(dec_a), 1);
    chk("R1 busy", int'(busy_a), 0);
    chk("R1 wake", int'(wake_a), 0);
    chk("R11 cap", int'(cap_a), int'(CAP));
    chk("R11 cap_b", int'(cap_b), int'(CAP));

    // sweep every reachable start state against every request
    foreach (ctrl_a[i]) begin end
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      for (int r = 0; r < 4; r++) begin
        do_reset();
        if (s != 0) do_wr(s, 1'b0, 1'b0, 1'b0);
        chk("R2 start", int'(ctrl_a[1:0]), ma);
        do_wr(r, 1'b0, 1'b0, 1'b0);
        chk("R3 state", int'(ctrl_a[1:0]), ma);
        chk("R4 state_b", int'(ctrl_b[1:0]), mb);
        chk("R5 dec", int'(dec_a), int'(ma == 0 && !ba));
        chk("R5 dec_b", int'(dec_b), int'(mb == 0 && !bb));
        chk("R6 busy", int'(busy_a), int'(ba));
        if (ba) begin
          int n = 0;
          while (busy_a && n < 1000) begin
            if (dec_a) chk("R6 dec in window", 1, 0);
            n++; @(negedge clk);
          end
          chk("R6 window", n, RC);
          chk("R6 dec after", int'(dec_a), 1);
        end
        wait_idle();
      end
    end

    // request ignored during recovery
    do_reset();
    do_wr(3, 1'b0, 1'b0, 1'b0);
    do_wr(0, 1'b0, 1'b0, 1'b0);
    do_wr(1, 1'b0, 1'b0, 1'b0);
    chk("R7 state", int'(ctrl_a[1:0]), 0);
    chk("R7 busy", int'(busy_a), 1);
    wait_idle();
    do_wr(1, 1'b0, 1'b0, 1'b0);
    chk("R7 after", int'(ctrl_a[1:0]), 1);

    // wake logic
    do_reset();
    do_wr(0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); evt = 1'b1; @(negedge clk); evt = 1'b0;
    chk("R8 sts D0", int'(ctrl_a[7]), 1);
    chk("R9 no en", int'(wake_a), 0);
    do_wr(0, 1'b1, 1'b0, 1'b0);
    chk("R9 en", int'(wake_a), 1);
    chk("R2 wen", int'(ctrl_a[4]), 1);
    do_wr(0, 1'b1, 1'b1, 1'b0);
    chk("R10 clr", int'(ctrl_a[7]), 0);
    chk("R9 cleared", int'(wake_a), 0);
    do_wr(0, 1'b1, 1'b1, 1'b1);
    chk("R10 set wins", int'(ctrl_a[7]), 1);
    do_wr(3, 1'b1, 1'b1, 1'b0);
    chk("R5 off", int'(ctrl_a[1:0]), 3);
    chk("R10 clr2", int'(ctrl_a[7]), 0);
    @(negedge clk); evt = 1'b1; @(negedge clk); evt = 1'b0;
    chk("R8 no cap off", int'(ctrl_a[7]), 0);
    chk("R8 wake off", int'(wake_a), 0);
    do_wr(0, 1'b1, 1'b0, 1'b0);
    wait_idle();
    do_wr(1, 1'b1, 1'b0, 1'b0);
    chk("R5 dec lite", int'(dec_a), 0);
    @(negedge clk); evt = 1'b1; @(negedge clk); evt = 1'b0;
    chk("R8 sts lite", int'(ctrl_a[7]), 1);
    chk("R9 wake lite", int'(wake_a), 1);
    do_wr(1, 1'b1, 1'b1, 1'b0);
    chk("R5 cfg in lite", int'(ctrl_a[7]), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule